// File: doc/BRIEF.md
# Coarse Tap Supervisor for a Hybrid Delay-Locked Oscillator

This block chooses the coarse setting of a delay-locked oscillator. The oscillator's half-period is a chain of delay cells, and each cell has a fine analog trim. The block selects how many cells are in the chain, from 2 up to TAPS-1. During acquisition it moves that count one step at a time until the analog trim node rests near the middle of its span. After lock, the analog loop tracks temperature and supply drift alone. A new tap is chosen only when the trim node leaves its usable window. That change is a deliberate frequency step.

The block reads three window-comparator flags from the analog trim node: below the low limit, above the high limit, and near the midpoint. It also takes a lock request. After every tap change it waits a programmable number of reference clocks before it reads the flags again, so that the analog loop can settle. It declares lock after a programmable number of consecutive near-midpoint samples. The analog cells, the phase comparator and the loop filter are outside this block.

Top module: `dl_tap_supervisor`

## Requirements
- R1: A synchronous active-high reset sets the tap index to TAPS/2 (16 by default) and clears `locked_o`, `retap_o` and `oor_o`. It also clears the settle wait, so flags are sampled on the first clock with the lock request high.
- R2: While `lock_req_i` is low, the tap index does not change, `retap_o` stays low, and `locked_o` and `oor_o` are low from the next clock.
- R3: On a sample clock (lock request high, no settle wait pending) with `ctl_high_i` set and tap below TAPS-1, the tap index rises by one at that clock edge, and `retap_o` is high for exactly that one cycle.
- R4: On a sample clock with `ctl_low_i` set, `ctl_high_i` clear and tap above 2, the tap index falls by one and `retap_o` pulses. When both flags are set, the high flag wins.
- R5: A step that would go above TAPS-1 or below 2 leaves the tap unchanged, produces no `retap_o`, and sets `oor_o`. `oor_o` clears on the next sample with neither limit flag set.
- R6: After a tap change, the flags are ignored for `settle_len_i` clocks. The first sample after the change comes `settle_len_i`+1 clocks after it.
- R7: `locked_o` rises at the sample clock that completes `lock_len_i` consecutive samples with `ctl_mid_i` set and no limit flag (a value of 0 acts as 1). Before lock, an in-window sample without `ctl_mid_i` restarts the count.
- R8: Once locked, in-window samples with or without `ctl_mid_i` keep `locked_o` high and the tap unchanged.
- R9: A tap change or a blocked step at a limit drops `locked_o` in the same cycle, and qualification starts again.
- R10: The tap index always lies within 2 to TAPS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| lock_req_i | input | 1 | Enables acquisition and tracking |
| ctl_low_i | input | 1 | Trim node below low window limit |
| ctl_high_i | input | 1 | Trim node above high window limit |
| ctl_mid_i | input | 1 | Trim node near its midpoint |
| settle_len_i | input | SETTLE_W | Clocks to wait after a tap change |
| lock_len_i | input | LOCK_W | Consecutive mid samples required for lock |
| tap_o | output | $clog2(TAPS) | Selected tap count |
| locked_o | output | 1 | Lock indication |
| retap_o | output | 1 | One-cycle pulse on each tap change |
| oor_o | output | 1 | Step requested beyond a tap limit |

## Verification
The flags are driven with the high limit held through a settle window, which separates sampling during the wait from sampling after it, and with both limit flags set at once to expose the priority between them. Midpoint runs broken by a single non-mid sample show whether the lock count restarts. Midpoint runs that finish the count show the exact lock cycle, and after lock, in-window non-mid samples show that lock is held. Long runs of a single limit flag drive the tap into both ends of its range, where a wrap-around or a missing out-of-range flag would show up. Every clock is compared against a behavioural reference model.

// File: rtl/dl_tap_pkg.sv
package dl_tap_pkg;
    // Smallest tap count the chain may run with (highest frequency).
    localparam int unsigned TAP_MIN = 2;
endpackage

// File: rtl/dl_tap_step.sv
module dl_tap_step
    import dl_tap_pkg::*;
#(
    parameter int unsigned TAPS = 32,
    parameter int unsigned TW   = 5
) (
    input  logic [TW-1:0] tap_i,
    input  logic          want_up_i,
    input  logic          want_dn_i,
    output logic [TW-1:0] tap_o,
    output logic          moved_o,
    output logic          blocked_o
);
    localparam logic [TW-1:0] TOP = TW'(TAPS - 1);
    localparam logic [TW-1:0] BOT = TW'(TAP_MIN);

    always_comb begin
        tap_o     = tap_i;
        moved_o   = 1'b0;
        blocked_o = 1'b0;
        if (want_up_i) begin
            if (tap_i >= TOP) begin
                blocked_o = 1'b1;
            end else begin
                tap_o   = tap_i + TW'(1);
                moved_o = 1'b1;
            end
        end else if (want_dn_i) begin
            if (tap_i <= BOT) begin
                blocked_o = 1'b1;
            end else begin
                tap_o   = tap_i - TW'(1);
                moved_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dl_settle_timer.sv
module dl_settle_timer #(
    parameter int unsigned CW = 12
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          load_i,
    input  logic [CW-1:0] len_i,
    output logic          idle_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = len_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    assign idle_o = (cnt_q == '0);
endmodule

// File: rtl/dl_lock_qual.sv
module dl_lock_qual #(
    parameter int unsigned LW = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          clear_i,
    input  logic          sample_i,
    input  logic          mid_i,
    input  logic [LW-1:0] len_i,
    output logic          locked_o
);
    typedef struct packed {
        logic [LW-1:0] cnt;
        logic          locked;
    } lq_t;

    lq_t s_d, s_q;
    logic [LW:0] target;
    logic [LW:0] bumped;

    assign target = (len_i == '0) ? (LW+1)'(1) : {1'b0, len_i};
    assign bumped = {1'b0, s_q.cnt} + (LW+1)'(1);

    always_comb begin
        s_d = s_q;
        if (clear_i) begin
            s_d.cnt    = '0;
            s_d.locked = 1'b0;
        end else if (sample_i && !s_q.locked) begin
            if (mid_i) begin
                if (s_q.cnt != '1) s_d.cnt = s_q.cnt + LW'(1);
                if (bumped >= target) s_d.locked = 1'b1;
            end else begin
                s_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '{cnt: '0, locked: 1'b0};
        else       s_q <= s_d;
    end

    assign locked_o = s_q.locked;
endmodule

// File: rtl/dl_tap_supervisor.sv
module dl_tap_supervisor
    import dl_tap_pkg::*;
#(
    parameter int unsigned TAPS     = 32,
    parameter int unsigned SETTLE_W = 12,
    parameter int unsigned LOCK_W   = 8
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     lock_req_i,
    input  logic                     ctl_low_i,
    input  logic                     ctl_high_i,
    input  logic                     ctl_mid_i,
    input  logic [SETTLE_W-1:0]      settle_len_i,
    input  logic [LOCK_W-1:0]        lock_len_i,
    output logic [$clog2(TAPS)-1:0]  tap_o,
    output logic                     locked_o,
    output logic                     retap_o,
    output logic                     oor_o
);
    localparam int unsigned   TW  = $clog2(TAPS);
    localparam logic [TW-1:0] MID = TW'(TAPS / 2);

    typedef struct packed {
        logic [TW-1:0] tap;
        logic          retap;
        logic          oor;
    } sup_t;

    sup_t s_d, s_q;

    logic          settle_idle;
    logic          sample;
    logic          want_up, want_dn;
    logic          moved, blocked;
    logic [TW-1:0] tap_next;
    logic          in_window;
    logic          lock_clear;

    assign sample    = lock_req_i && settle_idle;
    assign in_window = !ctl_high_i && !ctl_low_i;
    assign want_up   = sample && ctl_high_i;
    assign want_dn   = sample && ctl_low_i && !ctl_high_i;

    dl_tap_step #(.TAPS(TAPS), .TW(TW)) u_step (
        .tap_i     (s_q.tap),
        .want_up_i (want_up),
        .want_dn_i (want_dn),
        .tap_o     (tap_next),
        .moved_o   (moved),
        .blocked_o (blocked)
    );

    dl_settle_timer #(.CW(SETTLE_W)) u_settle (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (moved),
        .len_i  (settle_len_i),
        .idle_o (settle_idle)
    );

    assign lock_clear = !lock_req_i || moved || blocked;

    dl_lock_qual #(.LW(LOCK_W)) u_lock (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .clear_i  (lock_clear),
        .sample_i (sample && in_window),
        .mid_i    (ctl_mid_i),
        .len_i    (lock_len_i),
        .locked_o (locked_o)
    );

    always_comb begin
        s_d       = s_q;
        s_d.retap = 1'b0;
        if (!lock_req_i) begin
            s_d.oor = 1'b0;
        end else if (sample) begin
            if (moved) begin
                s_d.tap   = tap_next;
                s_d.retap = 1'b1;
            end
            if (blocked)   s_d.oor = 1'b1;
            if (in_window) s_d.oor = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '{tap: MID, retap: 1'b0, oor: 1'b0};
        else       s_q <= s_d;
    end

    assign tap_o   = s_q.tap;
    assign retap_o = s_q.retap;
    assign oor_o   = s_q.oor;
endmodule

// File: rtl/dl_tap_supervisor_chk.sv
module dl_tap_supervisor_chk #(
    parameter int unsigned TAPS = 32,
    parameter int unsigned TW   = 5
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          lock_req_i,
    input logic          ctl_high_i,
    input logic          settle_idle_i,
    input logic [TW-1:0] tap_i,
    input logic          locked_i,
    input logic          retap_i,
    input logic          oor_i
);
    assert_reset_state_R1: assert property (@(posedge clk_i)
        rst_i |=> (tap_i == TW'(TAPS / 2)) && !locked_i && !retap_i && !oor_i);

    assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !lock_req_i |=> $stable(tap_i) && !retap_i && !locked_i && !oor_i);

    assert_single_step_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        retap_i |-> (int'(tap_i) - int'($past(tap_i)) == 1) ||
                    (int'($past(tap_i)) - int'(tap_i) == 1));

    assert_top_saturate_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (lock_req_i && settle_idle_i && ctl_high_i && tap_i == TW'(TAPS - 1))
        |=> oor_i && $stable(tap_i) && !retap_i);

    assert_settle_quiet_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        !settle_idle_i |=> !retap_i && $stable(tap_i));

    assert_retap_unlocks_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        retap_i |-> !locked_i);

    assert_tap_range_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (tap_i >= TW'(2)) && (tap_i <= TW'(TAPS - 1)));
endmodule

bind dl_tap_supervisor dl_tap_supervisor_chk #(.TAPS(TAPS), .TW(TW)) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .lock_req_i    (lock_req_i),
    .ctl_high_i    (ctl_high_i),
    .settle_idle_i (settle_idle),
    .tap_i         (tap_o),
    .locked_i      (locked_o),
    .retap_i       (retap_o),
    .oor_i         (oor_o)
);

// File: tb/dl_tap_supervisor_bench.sv
module dl_tap_supervisor_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam int  TAPS = 32;
    localparam int  TW   = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lock_req = 1'b0;
    logic          lo = 1'b0, hi = 1'b0, mid = 1'b0;
    logic [11:0]   settle_len = 12'd3;
    logic [7:0]    lock_len = 8'd4;
    logic [TW-1:0] tap;
    logic          locked, retap, oor;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural reference state
    int m_tap = 16, m_scnt = 0, m_mcnt = 0;
    bit m_locked = 0, m_retap = 0, m_oor = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dl_tap_supervisor u_dl_tap_supervisor (
        .clk_i(clk), .rst_i(rst), .lock_req_i(lock_req),
        .ctl_low_i(lo), .ctl_high_i(hi), .ctl_mid_i(mid),
        .settle_len_i(settle_len), .lock_len_i(lock_len),
        .tap_o(tap), .locked_o(locked), .retap_o(retap), .oor_o(oor)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        int need;
        cycles++;
        m_retap = 0;
        if (rst) begin
            m_tap = 16; m_scnt = 0; m_mcnt = 0; m_locked = 0; m_oor = 0;
        end else begin
            bit smp;
            smp = lock_req && (m_scnt == 0);
            if (m_scnt > 0) m_scnt--;
            need = (lock_len == 0) ? 1 : int'(lock_len);
            if (!lock_req) begin
                m_oor = 0; m_locked = 0; m_mcnt = 0;
            end else if (smp) begin
                if (hi || lo) begin
                    if ((hi && m_tap == TAPS-1) || (!hi && m_tap == 2)) begin
                        m_oor = 1;
                    end else begin
                        m_tap = hi ? m_tap + 1 : m_tap - 1;
                        m_retap = 1;
                        m_scnt = int'(settle_len);
                    end
                    m_locked = 0; m_mcnt = 0;
                end else begin
                    m_oor = 0;
                    if (!m_locked) begin
                        if (mid) begin
                            m_mcnt++;
                            if (m_mcnt >= need) m_locked = 1;
                        end else begin
                            m_mcnt = 0;
                        end
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check(int'(tap) == m_tap, "R3 R4 model tap", int'(tap), m_tap);
            check(retap == m_retap, "R6 model retap", retap, m_retap);
            check(locked == m_locked, "R7 model locked", locked, m_locked);
            check(oor == m_oor, "R5 model oor", oor, m_oor);
        end
        if (cycles > 20000) begin
            check(1'b0, "watchdog", cycles, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic flags(input bit l, input bit h, input bit m);
        lo = l; hi = h; mid = m;
    endtask

    initial begin
        tick(4);
        rst = 1'b0;
        // R1 reset state
        check(tap == 5'd16 && !locked && !retap && !oor, "R1 reset", int'(tap), 16);

        // R2 no action without lock request
        flags(0, 1, 0);
        tick(5);
        check(tap == 5'd16 && !retap && !locked, "R2 idle hold", int'(tap), 16);

        // R3 step up, R6 settle window ignores flags
        lock_req = 1'b1;
        tick(1);
        check(tap == 5'd17 && retap, "R3 step up", int'(tap), 17);
        tick(3);
        check(tap == 5'd17 && !retap, "R6 settle hold", int'(tap), 17);
        flags(0, 0, 0);
        tick(1);
        check(tap == 5'd17, "R6 in-window after settle", int'(tap), 17);

        // R4 priority: both limits set, high wins
        flags(1, 1, 0);
        tick(1);
        check(tap == 5'd18 && retap, "R4 high priority", int'(tap), 18);
        flags(0, 0, 0);
        tick(4);
        flags(1, 0, 0);
        tick(1);
        check(tap == 5'd17 && retap, "R4 step down", int'(tap), 17);
        flags(0, 0, 0);
        tick(4);

        // R7 broken run restarts, full run locks
        flags(0, 0, 1); tick(3);
        flags(0, 0, 0); tick(1);
        flags(0, 0, 1); tick(3);
        check(!locked, "R7 restart count", locked, 0);
        tick(1);
        check(locked, "R7 lock after run", locked, 1);

        // R8 in-window non-mid keeps lock
        flags(0, 0, 0); tick(5);
        check(locked && tap == 5'd17, "R8 hold lock", locked, 1);

        // R9 retap drops lock
        flags(0, 1, 0); tick(1);
        check(!locked && retap && tap == 5'd18, "R9 retap unlock", locked, 0);

        // R5 upper saturation
        tick(80);
        check(tap == 5'd31 && oor && !retap, "R5 top limit", int'(tap), 31);
        flags(0, 0, 0); tick(1);
        check(!oor, "R5 oor clear", oor, 0);

        // R5 lower saturation, R10 range
        flags(1, 0, 0); tick(150);
        check(tap == 5'd2 && oor, "R5 bottom limit", int'(tap), 2);
        check(tap >= 5'd2, "R10 range floor", int'(tap), 2);

        // R7 zero length acts as one; R2 drop of request clears lock
        flags(0, 0, 0); lock_len = 8'd0; tick(2);
        flags(0, 0, 1); tick(1);
        check(locked, "R7 zero length", locked, 1);
        lock_req = 1'b0; tick(1);
        check(!locked && !oor && tap == 5'd2, "R2 request drop", locked, 0);

        // R1 reset mid-run
        rst = 1'b1; tick(2);
        check(tap == 5'd16 && !locked && !oor, "R1 reset again", int'(tap), 16);
        rst = 1'b0;
        tick(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule